// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block watches inbound memory writes on a snoop port. It picks out the ones that are interrupt messages for one programmed target address and records each one as a pending bit in a 32-entry bitmap. A write is a message when its address equals the target, reception is enabled, and its data word fits a programmable pattern. The low bits of the data word select which vector becomes pending. The block drives one interrupt line: it is high when at least one pending vector is also unmasked.

Software uses a small word-indexed register port. Through it, software sets the target address and the data pattern, reads the pending bitmap, acknowledges vectors with write-one-to-clear, unmasks vectors, and signals end of service. An end-of-service write makes the interrupt line drop for one cycle. The line then comes back if work is still pending, so an edge-sensitive interrupt controller sees a fresh edge. Software handles vector allocation, and this block does not do it.

Top module: `msi_receiver`

## Requirements
- R1: After reset the pending bitmap is zero, every vector is masked, reception is disabled (target-low register reads 0) and `irqOut` is low.
- R2: Register indices are 0 target-low, 1 target-high, 2 pattern, 3 pending (read only), 4 clear, 5 unmask, 6 end-of-service. A read pulse on `regRdEn` returns the register's value on `regRdData` one cycle later, with `regRdValid` high for that cycle. Indices 0 to 2 read back what was written.
- R3: Bit 0 of target-low is the enable flag. The target address is {target-high, target-low[31:1], 0}.
- R4: An inbound write is a message when all of these hold: `snpValid` is high, the enable flag is 1, `snpAddr` equals the target, `snpData[31:16]` is zero, and (`snpData[15:0]` XOR pattern[15:0]) AND pattern[31:16] is zero. Pattern[31:16] is the compare mask.
- R5: A message sets pending bit `snpData[4:0]` at the next clock edge.
- R6: An inbound write is ignored when its address differs from the target or when the enable flag is 0. It is also ignored when its data fails the pattern test.
- R7: A write to the clear register clears every pending bit where the written word has a 1 and leaves the other bits unchanged. Writing all ones empties the bitmap.
- R8: When a message sets a bit in the same cycle that a clear write clears it, the bit ends up set.
- R9: A write to the unmask register unmasks every vector where the written word has a 1. `irqOut` is high exactly when some pending bit is unmasked, apart from the end-of-service case in R10.
- R10: A write to the end-of-service register with bit 0 = 1 holds `irqOut` low for one cycle. After that, `irqOut` is high again if a pending unmasked bit remains. With bit 0 = 0 the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, one cycle after the read strobe |
| regRdValid | output | 1 | Read data valid |
| snpValid | input | 1 | Inbound write valid |
| snpAddr | input | 64 | Inbound write address |
| snpData | input | 32 | Inbound write data |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties:
- `irqOut` is never high without a pending unmasked vector.
- The line is low in the cycle after an end-of-service write.
- Pending bits appear only in a cycle that had inbound write traffic, and at most one appears per cycle.
- A clear with no concurrent traffic really empties the bits it names.

Only the bench scenarios can show the rest:
- The address, enable and data-pattern filters reject each kind of mismatch.
- A message arriving with a clear of the same bit in one cycle wins.
- The line comes back after end of service when work remains.
- The exact pending values read back through the register port.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_PATTERN = 3'd2,
    SEL_PENDING = 3'd3,
    SEL_CLEAR   = 3'd4,
    SEL_UNMASK  = 3'd5,
    SEL_EOS     = 3'd6,
    SEL_SPARE   = 3'd7
  } regSelE;

  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldPattern;
    logic clrPend;
    logic unmask;
    logic gateIrq;
  } strobeT;
endpackage

// File: rtl/msi_rx_ctrl.sv
module msi_rx_ctrl
  import msi_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regAddr,
  input  logic             wrBit0,
  output strobeT           strobes
);
  logic eosHold;
  regSelE sel;

  assign sel = regSelE'(regAddr);

  // End-of-service write gates the interrupt line for exactly one cycle.
  always_ff @(posedge clk) begin
    if (!rstN) eosHold <= 1'b0;
    else       eosHold <= regWrEn && (sel == SEL_EOS) && wrBit0;
  end

  always_comb begin
    strobes           = '0;
    strobes.ldAddrLo  = regWrEn && (sel == SEL_ADDR_LO);
    strobes.ldAddrHi  = regWrEn && (sel == SEL_ADDR_HI);
    strobes.ldPattern = regWrEn && (sel == SEL_PATTERN);
    strobes.clrPend   = regWrEn && (sel == SEL_CLEAR);
    strobes.unmask    = regWrEn && (sel == SEL_UNMASK);
    strobes.gateIrq   = eosHold;
  end
endmodule

// File: rtl/msi_rx_datapath.sv
module msi_rx_datapath
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic               regRdEn,
  input  logic [SEL_W-1:0]   regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               regRdValid,
  input  logic               snpValid,
  input  logic [2*REG_W-1:0] snpAddr,
  input  logic [REG_W-1:0]   snpData,
  output logic [NUM_VEC-1:0] pendBits,
  output logic [NUM_VEC-1:0] maskBits
);
  localparam int VEC_W  = $clog2(NUM_VEC);
  localparam int HALF_W = REG_W / 2;

  logic [REG_W-1:0]   addrLo, addrHi, pattern;
  logic [2*REG_W-1:0] target;
  logic               addrHit, dataHit, msgHit;
  logic [HALF_W-1:0]  cmpMask;
  logic [VEC_W-1:0]   vecIdx;
  logic [NUM_VEC-1:0] setBits, clrBits;

  assign target  = {addrHi, addrLo[REG_W-1:1], 1'b0};
  assign cmpMask = pattern[REG_W-1:HALF_W];
  assign addrHit = snpValid && addrLo[0] && (snpAddr == target);
  assign dataHit = (snpData[REG_W-1:HALF_W] == '0) &&
                   (((snpData[HALF_W-1:0] ^ pattern[HALF_W-1:0]) & cmpMask) == '0);
  assign msgHit  = addrHit && dataHit;
  assign vecIdx  = snpData[VEC_W-1:0];
  assign setBits = msgHit ? (NUM_VEC'(1) << vecIdx) : '0;
  assign clrBits = strobes.clrPend ? regWrData[NUM_VEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      pattern <= '0;
    end else begin
      if (strobes.ldAddrLo)  addrLo  <= regWrData;
      if (strobes.ldAddrHi)  addrHi  <= regWrData;
      if (strobes.ldPattern) pattern <= regWrData;
    end
  end

  // Set has priority over a concurrent clear so no message is lost.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBits <= '0;
      maskBits <= '1;
    end else begin
      pendBits <= (pendBits & ~clrBits) | setBits;
      if (strobes.unmask) maskBits <= maskBits & ~regWrData[NUM_VEC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) begin
        unique case (regSelE'(regAddr))
          SEL_ADDR_LO: regRdData <= addrLo;
          SEL_ADDR_HI: regRdData <= addrHi;
          SEL_PATTERN: regRdData <= pattern;
          SEL_PENDING: regRdData <= REG_W'(pendBits);
          default:     regRdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/msi_receiver.sv
module msi_receiver
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [SEL_W-1:0]   regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               regRdValid,
  input  logic               snpValid,
  input  logic [2*REG_W-1:0] snpAddr,
  input  logic [REG_W-1:0]   snpData,
  output logic               irqOut
);
  strobeT             strobes;
  logic [NUM_VEC-1:0] pendBits, maskBits;

  msi_rx_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrBit0  (regWrData[0]),
    .strobes (strobes)
  );

  msi_rx_datapath #(.NUM_VEC(NUM_VEC)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .regRdValid (regRdValid),
    .snpValid   (snpValid),
    .snpAddr    (snpAddr),
    .snpData    (snpData),
    .pendBits   (pendBits),
    .maskBits   (maskBits)
  );

  assign irqOut = !strobes.gateIrq && |(pendBits & ~maskBits);
endmodule

// File: rtl/msi_receiver_chk.sv
module msi_receiver_chk
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [SEL_W-1:0]   regAddr,
  input logic [REG_W-1:0]   regWrData,
  input logic               snpValid,
  input logic               irqOut,
  input logic [NUM_VEC-1:0] pendBits,
  input logic [NUM_VEC-1:0] maskBits
);
  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> |(pendBits & ~maskBits));

  // R10
  eos_drops_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_EOS && regWrData[0]) |=> !irqOut);

  // R5
  set_only_by_traffic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |=> ((pendBits & ~$past(pendBits)) == '0));

  // R5
  one_new_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $onehot0(pendBits & ~$past(pendBits)));

  // R7
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_CLEAR && !snpValid)
      |=> ((pendBits & $past(regWrData[NUM_VEC-1:0])) == '0));
endmodule

bind msi_receiver msi_receiver_chk #(.NUM_VEC(NUM_VEC)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .snpValid  (snpValid),
  .irqOut    (irqOut),
  .pendBits  (pendBits),
  .maskBits  (maskBits)
);

// File: tb/test_msi_receiver.sv
`timescale 1ns/1ps
module test_msi_receiver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        snpValid = 1'b0;
  logic [63:0] snpAddr = '0;
  logic [31:0] snpData = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [63:0] TGT = 64'h0000_0001_2345_6780;

  always #2.5 clk = ~clk;

  msi_receiver i_msi_receiver (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .snpValid(snpValid), .snpAddr(snpAddr),
    .snpData(snpData), .irqOut(irqOut)
  );

  // Monitor: pops one expected read per valid beat.
  always @(negedge clk) begin
    if (regRdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%h exp=none", regRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, regRdData, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk); #1;
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic snoop(input logic [63:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    snpValid = 1'b1; snpAddr = a; snpData = d;
    @(posedge clk); #1;
    snpValid = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", t, irqOut, e);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b0, "R1 reset");
    regRead(3'd3, 32'h0, "R1 pending after reset");
    regRead(3'd0, 32'h0, "R1 target-low after reset");

    // R2 R3 programming and readback
    regWrite(3'd0, 32'h2345_6781);
    regWrite(3'd1, 32'h0000_0001);
    regWrite(3'd2, 32'hFFE0_6540);
    regRead(3'd0, 32'h2345_6781, "R2 target-low readback");
    regRead(3'd1, 32'h0000_0001, "R2 target-high readback");
    regRead(3'd2, 32'hFFE0_6540, "R2 pattern readback");

    // R5 message sets vector 5; R1 still masked
    snoop(TGT, 32'h0000_6545);
    regRead(3'd3, 32'h0000_0020, "R5 vector 5 pending");
    checkIrq(1'b0, "R1 masked after reset");

    // R9 partial unmask
    regWrite(3'd5, 32'h0000_0020);
    checkIrq(1'b1, "R9 unmasked vector 5");
    regWrite(3'd4, 32'h0000_0020);
    checkIrq(1'b0, "R9 cleared vector 5");
    snoop(TGT, 32'h0000_6540);
    checkIrq(1'b0, "R9 vector 0 still masked");
    regWrite(3'd5, 32'hFFFF_FFFF);
    checkIrq(1'b1, "R9 unmask all");

    // R6 address mismatch, then disabled
    snoop(TGT + 64'h4, 32'h0000_6542);
    snoop(64'h0000_0000_2345_6780, 32'h0000_6542);
    regRead(3'd3, 32'h0000_0001, "R6 wrong address ignored");
    regWrite(3'd0, 32'h2345_6780);
    snoop(TGT, 32'h0000_6542);
    regRead(3'd3, 32'h0000_0001, "R6 R3 disabled ignored");
    regWrite(3'd0, 32'h2345_6781);

    // R4 pattern mismatch and nonzero upper half
    snoop(TGT, 32'h0000_7542);
    snoop(TGT, 32'h0001_6542);
    regRead(3'd3, 32'h0000_0001, "R4 data mismatch ignored");

    // R5 R4 vector 31 (compare mask ignores low 5 bits)
    snoop(TGT, 32'h0000_655F);
    snoop(TGT, 32'h0000_6545);
    regRead(3'd3, 32'h8000_0021, "R5 vectors 0 5 31");

    // R7 selective clear
    regWrite(3'd4, 32'h0000_0020);
    regRead(3'd3, 32'h8000_0001, "R7 clear vector 5");

    // R10 end of service
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'd6; regWrData = 32'h1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    checkIrq(1'b0, "R10 line dropped after end of service");
    @(posedge clk); #1;
    checkIrq(1'b1, "R10 line back with work pending");
    regWrite(3'd6, 32'h0);
    checkIrq(1'b1, "R10 bit0 zero has no effect");

    // R8 set wins over concurrent clear
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'h0000_0009;
    snpValid = 1'b1; snpAddr = TGT; snpData = 32'h0000_6543;
    @(posedge clk); #1;
    regWrEn = 1'b0; snpValid = 1'b0;
    regRead(3'd3, 32'h8000_0008, "R8 set wins, vector 0 cleared");

    // R7 clear all
    regWrite(3'd4, 32'hFFFF_FFFF);
    regRead(3'd3, 32'h0, "R7 clear all");
    checkIrq(1'b0, "R9 nothing pending");

    repeat (4) @(posedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL reads missing act=%0d exp=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule